// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Sequencer

This block sits between a synchronous host and an external 64K x 16 asynchronous static RAM. The memory is controlled by an active-high chip select, two active-low byte-lane controls, an active-low write strobe and an active-low output enable. The host issues one request at a time over a valid/ready port. Each request carries a direction, a 16-bit word address, a 2-bit lane mask and write data. The sequencer turns the request into a pin sequence on the memory that respects address and data setup and hold.

A write drives the address, the data and the lane controls for one setup cycle. The write strobe is then held low for a programmable number of cycles. One hold cycle follows, in which the strobe is already released and everything else is held, so the memory captures the data on the strobe edge. A read asserts output enable and the lane controls for a programmable number of cycles. The data bus is sampled at the end of the last of these cycles and returned as a one-cycle response. Between requests the memory is parked in standby.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset: mem_cs=0, mem_bc1_n=1, mem_bc2_n=1, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0, rsp_valid=0, req_ready=1.
- R2: Lane mask bit 0 selects data bits 7:0 and drives mem_bc1_n low. Bit 1 selects bits 15:8 and drives mem_bc2_n low. Both bits set drive both controls low for the full word. A control whose lane is not selected stays high for the whole access.
- R3: A write presents one setup cycle with mem_cs high, the lane controls active and mem_we_n high. It then holds mem_we_n low for exactly WE_CYCLES cycles. One hold cycle follows with mem_we_n high while mem_cs and the lane controls stay active. After that the memory returns to standby.
- R4: During a write, mem_addr and mem_dq_out hold the request's address and data from the setup cycle through the hold cycle. mem_dq_oe is high for exactly those WE_CYCLES+2 cycles, and it is low during reads and while idle.
- R5: mem_oe_n is high in every cycle in which mem_we_n is low.
- R6: A read holds mem_oe_n low, with mem_cs high, the lane controls active and mem_we_n high, for exactly READ_WAIT cycles. rsp_valid is high for exactly one cycle, the cycle after the last one with mem_oe_n low. The request is accepted at clock edge 0, and rsp_valid is first seen after edge READ_WAIT.
- R7: rsp_rdata carries mem_dq_in as sampled at the end of the last output-enable cycle, with the bits of unselected lanes forced to zero.
- R8: A request with lane mask 00 is accepted and dropped. The memory pins do not leave standby, no response is produced, req_ready stays high, and the memory contents are unchanged.
- R9: req_ready is high only while the sequencer is idle. Whenever it is high, the memory is in standby (mem_cs=0, both lane controls high, mem_we_n=1, mem_oe_n=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_be | input | 2 | Lane mask (bit 0 low byte, bit 1 high byte) |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 16 | Memory address |
| mem_cs | output | 1 | Chip select, active high |
| mem_bc1_n | output | 1 | Low-lane control, active low |
| mem_bc2_n | output | 1 | High-lane control, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
The hardest case to reach is a partial-lane write followed later by a read of the other lane or of the full word. Only that sequence shows whether a lane control was briefly active when it should not have been, or whether a write committed on the wrong edge. The bench models the memory from the pins alone. Its model commits a lane only on the rising edge of the write strobe and only while chip select and that lane's control are still active, and it drives a fixed non-zero pattern on unselected lanes. Random addresses are drawn from a small pool so that byte writes, masked reads and empty-mask requests pile up on the same words.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RDWAIT = 3'd4
  } seq_state_t;
endpackage

// File: rtl/sram_lane_timer.sv
`timescale 1ns/1ps
// Cycle counter restarted on every state change; flags the final cycle.
module sram_lane_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == limit);
endmodule

// File: rtl/sram_lane_decode.sv
`timescale 1ns/1ps
// Lane mask to active-low lane controls.
module sram_lane_decode #(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0] lane_sel,
  input  logic             active,
  output logic [LANES-1:0] lane_n
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_n[i] = ~(active & lane_sel[i]);
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int WE_CYCLES = 2,
  parameter int READ_WAIT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_be,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs,
  output logic          mem_bc1_n,
  output logic          mem_bc2_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int LANES  = DW / LANE_W;
  localparam int MAXC   = (WE_CYCLES > READ_WAIT) ? WE_CYCLES : READ_WAIT;
  localparam int CW     = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WE_LIM = CW'(WE_CYCLES - 1);
  localparam logic [CW-1:0] RD_LIM = CW'(READ_WAIT - 1);

  seq_state_t        state_q, state_d;
  logic [LANES-1:0]  be_q, be_d, lane_n_d, lane_n_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q, rd_mask, rdata_q;
  logic              accept, t_last, rd_done;
  logic              cs_q, we_n_q, oe_n_q, dq_oe_q, rsp_valid_q;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready && (req_be != 2'b00);
  assign rd_done   = (state_q == ST_RDWAIT) && t_last;

  sram_lane_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (state_d != state_q),
    .limit   ((state_q == ST_WPULSE) ? WE_LIM : RD_LIM),
    .last    (t_last)
  );

  always_comb begin
    state_d = state_q;
    be_d    = be_q;
    case (state_q)
      ST_IDLE: if (accept) begin
        be_d    = LANES'(req_be);
        state_d = req_write ? ST_WSETUP : ST_RDWAIT;
      end
      ST_WSETUP: state_d = ST_WPULSE;
      ST_WPULSE: if (t_last) state_d = ST_WHOLD;
      ST_WHOLD:  state_d = ST_IDLE;
      ST_RDWAIT: if (t_last) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  sram_lane_decode #(.LANES(LANES)) u_pin_dec (
    .lane_sel (be_d),
    .active   (state_d != ST_IDLE),
    .lane_n   (lane_n_d)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_mask
    assign rd_mask[i*LANE_W +: LANE_W] = {LANE_W{be_q[i]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      be_q        <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      cs_q        <= 1'b0;
      lane_n_q    <= '1;
      we_n_q      <= 1'b1;
      oe_n_q      <= 1'b1;
      dq_oe_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      state_q  <= state_d;
      be_q     <= be_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      cs_q     <= (state_d != ST_IDLE);
      lane_n_q <= lane_n_d;
      we_n_q   <= (state_d != ST_WPULSE);
      oe_n_q   <= (state_d != ST_RDWAIT);
      dq_oe_q  <= (state_d == ST_WSETUP) || (state_d == ST_WPULSE) ||
                  (state_d == ST_WHOLD);
      rsp_valid_q <= rd_done;
      if (rd_done) rdata_q <= mem_dq_in & rd_mask;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_cs     = cs_q;
  assign mem_bc1_n  = lane_n_q[0];
  assign mem_bc2_n  = lane_n_q[LANES-1];
  assign mem_we_n   = we_n_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_dq_oe  = dq_oe_q;
  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rdata_q;

  // Assertions
  p_oe_off_in_write_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  p_we_fall_after_setup_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> $past(mem_cs) && $stable(mem_addr) && $past(mem_dq_oe));

  p_we_release_first_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> mem_cs && !(mem_bc1_n && mem_bc2_n));

  p_write_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |=> $stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe);

  p_driver_only_write_r4: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n && mem_cs);

  p_read_pins_r6: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> mem_we_n && mem_cs && !(mem_bc1_n && mem_bc2_n));

  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_rsp_after_oe_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> mem_oe_n && !$past(mem_oe_n));

  p_rsp_mask_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (!$past(mem_bc1_n) || rsp_rdata[LANE_W-1:0] == '0) &&
                  (!$past(mem_bc2_n) || rsp_rdata[DW-1:DW-LANE_W] == '0));

  p_idle_standby_r9: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_cs && mem_bc1_n && mem_bc2_n && mem_we_n && mem_oe_n);
endmodule

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;
  localparam int WE_CYCLES = 2;
  localparam int READ_WAIT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_out, mem_dq_in;
  logic        mem_cs, mem_bc1_n, mem_bc2_n, mem_we_n, mem_oe_n, mem_dq_oe;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [15:0] sram [256];
  logic [15:0] refm [256];
  logic prev_we = 1'b1;

  always #10 clk = ~clk;

  sram_lane_ctrl #(.WE_CYCLES(WE_CYCLES), .READ_WAIT(READ_WAIT)) i_sram_lane_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs(mem_cs), .mem_bc1_n(mem_bc1_n),
    .mem_bc2_n(mem_bc2_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Pin-level memory model: lanes drive only when selected and read-enabled.
  assign mem_dq_in[15:8] = (mem_cs && !mem_bc2_n && !mem_oe_n && mem_we_n) ?
                           sram[mem_addr[7:0]][15:8] : 8'h5A;
  assign mem_dq_in[7:0]  = (mem_cs && !mem_bc1_n && !mem_oe_n && mem_we_n) ?
                           sram[mem_addr[7:0]][7:0] : 8'hA5;

  // Commit on the rising write strobe while select and lane are still active.
  always @(negedge clk) begin
    if (!rst && !prev_we && mem_we_n && mem_cs) begin
      if (!mem_bc1_n) sram[mem_addr[7:0]][7:0]  <= mem_dq_oe ? mem_dq_out[7:0]  : 8'h00;
      if (!mem_bc2_n) sram[mem_addr[7:0]][15:8] <= mem_dq_oe ? mem_dq_out[15:8] : 8'h00;
    end
    prev_we <= mem_we_n;
  end

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_standby(input string tag);
    check(!mem_cs && mem_bc1_n && mem_bc2_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready,
          tag, {mem_cs, mem_bc1_n, mem_bc2_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready},
          7'b0111101);
  endtask

  task automatic run_op(input bit wr, input logic [15:0] a, input logic [1:0] be,
                        input logic [15:0] d);
    int cs_cnt = 0, we_cnt = 0, oe_cnt = 0, dqoe_cnt = 0, rsp_cnt = 0, rsp_at = 0;
    int lane_bad = 0, addr_bad = 0, data_bad = 0, clash = 0;
    bit first_we_hi = 1'b0, last_we_hi = 1'b0;
    logic [15:0] rdata = '0, exp;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = ~d; req_addr = ~a;
    for (int n = 1; n <= 40; n++) begin
      if (n > 1) @(negedge clk);
      if (mem_cs) begin
        cs_cnt++;
        if (mem_bc1_n != !be[0] || mem_bc2_n != !be[1]) lane_bad++;
        if (mem_addr != a) addr_bad++;
        if (n == 1) first_we_hi = mem_we_n;
        last_we_hi = mem_we_n;
      end
      if (!mem_we_n) we_cnt++;
      if (!mem_we_n && !mem_oe_n) clash++;
      if (!mem_oe_n) oe_cnt++;
      if (mem_dq_oe) begin
        dqoe_cnt++;
        if (mem_dq_out != d) data_bad++;
      end
      if (rsp_valid) begin rsp_cnt++; rsp_at = n; rdata = rsp_rdata; end
      if (req_ready && (wr || rsp_cnt > 0)) break;
    end
    check(lane_bad == 0, "R2 lane controls", lane_bad, 0);
    check(clash == 0, "R5 oe during we", clash, 0);
    if (wr) begin
      check(first_we_hi && last_we_hi, "R3 setup/hold strobe high",
            {first_we_hi, last_we_hi}, 2'b11);
      check(we_cnt == WE_CYCLES, "R3 strobe width", we_cnt, WE_CYCLES);
      check(cs_cnt == WE_CYCLES + 2, "R3 select span", cs_cnt, WE_CYCLES + 2);
      check(dqoe_cnt == WE_CYCLES + 2 && data_bad == 0 && addr_bad == 0,
            "R4 driver span/data", dqoe_cnt, WE_CYCLES + 2);
      for (int i = 0; i < 16; i++) if (be[i/8]) refm[a[7:0]][i] = d[i];
    end else begin
      exp = refm[a[7:0]] & lane_mask(be);
      check(oe_cnt == READ_WAIT && cs_cnt == READ_WAIT && we_cnt == 0 && dqoe_cnt == 0,
            "R6 read window", oe_cnt, READ_WAIT);
      check(rsp_cnt == 1 && rsp_at == READ_WAIT + 1, "R6 response timing", rsp_at,
            READ_WAIT + 1);
      check(rdata == exp, "R7 read data", rdata, exp);
    end
    check_standby("R9 standby after op");
    if (!wr) begin
      @(negedge clk);
      check(!rsp_valid, "R6 single pulse", rsp_valid, 0);
    end
  endtask

  task automatic run_empty(input bit wr, input logic [15:0] a);
    int act = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = 2'b00; req_wdata = 16'hDEAD;
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 0; n < 6; n++) begin
      if (mem_cs || !mem_we_n || !mem_oe_n || rsp_valid || !req_ready) act++;
      @(negedge clk);
    end
    check(act == 0, "R8 empty mask ignored", act, 0);
  endtask

  initial begin
    int unused_seed;
    for (int i = 0; i < 256; i++) begin
      sram[i] = 16'(i * 16'h0123 + 16'h0F0F);
      refm[i] = sram[i];
    end
    unused_seed = $urandom(32'h5EED1234);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    check(!rsp_valid, "R1 rsp after reset", rsp_valid, 0);
    check_standby("R1 pins after reset");

    run_op(1'b1, 16'h0000, 2'b11, 16'hBEEF);
    run_op(1'b0, 16'h0000, 2'b11, 16'h0);
    run_op(1'b1, 16'hFFFF, 2'b10, 16'h12AB);   // R2 upper lane only
    run_op(1'b0, 16'hFFFF, 2'b11, 16'h0);
    run_op(1'b0, 16'hFFFF, 2'b01, 16'h0);      // R7 lower lane masked read
    run_op(1'b1, 16'h0040, 2'b01, 16'h77C3);
    run_op(1'b0, 16'h0040, 2'b10, 16'h0);
    run_empty(1'b1, 16'h0040);
    run_empty(1'b0, 16'h0040);
    run_op(1'b0, 16'h0040, 2'b11, 16'h0);      // R8 contents unchanged

    for (int k = 0; k < 300; k++) begin
      logic [15:0] a;
      logic [1:0]  be;
      a  = {8'($urandom), 5'd0, 3'($urandom)};
      be = 2'($urandom);
      if (be == 2'b00) run_empty(1'($urandom), a);
      else run_op(1'($urandom), a, be, 16'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule